// File: doc/BRIEF.md
# Tennis Game Point Scorer

This block keeps the point score of one tennis game between two players, A and B. Each clock cycle, two point strobes report who won the last rally. The block advances that player's score through love, 15, 30 and 40. Leveling at 40 moves the game into deuce. From deuce, a player needs two points in a row to take the game.

It is a Moore machine, so both win flags come from registered state alone. A decided game stays decided until it is restarted. A restart can come from a synchronous clear strobe or from the asynchronous reset. The current phase and the two per-player point codes are exported, so that downstream logic can show the score.

Top module: `tennis_score`

## Requirements
- R1: While rst_ni is low, and after it is released, the state is love-love: phase_o = 0 (playing), pts_a_o = pts_b_o = 0, and both win outputs are low.
- R2: During play, a cycle with only a_i high (or only b_i high) raises that player's point code by one at the next edge. The point codes are 0 = love, 1 = 15, 2 = 30, 3 = 40.
- R3: During play, a point by a player already at 40, while the opponent is below 40, moves the phase to that player's win code (4 for A, 5 for B).
- R4: A point that brings the trailing player from 30 to 40 while the leader is at 40 enters deuce: phase_o = 1, both point codes 3.
- R5: In deuce, a single point moves the phase to the scorer's advantage code: 2 for A, 3 for B.
- R6: In advantage, a point by the holder wins the game. A point by the other player returns the phase to deuce (1).
- R7: A cycle with a_i and b_i both high, or both low, leaves phase and point codes unchanged.
- R8: In a win phase, the outputs hold and point inputs are ignored until the game is restarted.
- R9: clear_i high at a clock edge restarts the game at love-love on that edge. It has priority over the point inputs.
- R10: a_wins_o is high exactly in phase 4 and b_wins_o exactly in phase 5. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous restart of the game |
| a_i | input | 1 | Player A won the rally this cycle |
| b_i | input | 1 | Player B won the rally this cycle |
| phase_o | output | 3 | Game phase: 0 play, 1 deuce, 2 adv A, 3 adv B, 4 A won, 5 B won |
| pts_a_o | output | 2 | Player A point code |
| pts_b_o | output | 2 | Player B point code |
| a_wins_o | output | 1 | Player A has won the game |
| b_wins_o | output | 1 | Player B has won the game |

## Verification
The bench builds the block with the package widths at their defaults: a 2-bit point code and a 3-bit phase code, which is the only width at which the four tennis scores fit exactly. Directed games reach straight wins for each player. They also reach deuce from both 40-30 and 30-40, and advantage lost and regained several times. Long random rally streams, with clear and tie cycles mixed in, reach every phase-to-phase arc and the behaviour of restarting from a win.

// File: rtl/tennis_pkg.sv
package tennis_pkg;
  localparam int PTS_W = 2;
  localparam int PH_W  = 3;
  localparam logic [PTS_W-1:0] PTS_LOVE  = '0;
  localparam logic [PTS_W-1:0] PTS_FORTY = '1;

  typedef enum logic [PH_W-1:0] {
    PH_PLAY  = 3'd0,
    PH_DEUCE = 3'd1,
    PH_ADV_A = 3'd2,
    PH_ADV_B = 3'd3,
    PH_WIN_A = 3'd4,
    PH_WIN_B = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_A    = 2'd1,
    EV_B    = 2'd2
  } point_e;

  typedef struct packed {
    phase_e           phase;
    logic [PTS_W-1:0] pts_a;
    logic [PTS_W-1:0] pts_b;
  } score_t;

  localparam score_t SCORE_INIT = '{phase: PH_PLAY, pts_a: PTS_LOVE, pts_b: PTS_LOVE};
endpackage

// File: rtl/tennis_point_decode.sv
module tennis_point_decode
  import tennis_pkg::*;
(
  input  logic   a_i,
  input  logic   b_i,
  output point_e ev_o
);
  // simultaneous or absent strobes carry no point
  always_comb begin
    unique case ({a_i, b_i})
      2'b10:   ev_o = EV_A;
      2'b01:   ev_o = EV_B;
      default: ev_o = EV_NONE;
    endcase
  end
endmodule

// File: rtl/tennis_next.sv
module tennis_next
  import tennis_pkg::*;
(
  input  score_t cur_i,
  input  point_e ev_i,
  output score_t nxt_o
);
  logic [PTS_W-1:0] inc_a, inc_b;

  assign inc_a = cur_i.pts_a + 1'b1;
  assign inc_b = cur_i.pts_b + 1'b1;

  always_comb begin
    nxt_o = cur_i;
    unique case (cur_i.phase)
      PH_PLAY: begin
        if (ev_i == EV_A) begin
          if (cur_i.pts_a == PTS_FORTY) begin
            nxt_o.phase = PH_WIN_A;
          end else begin
            nxt_o.pts_a = inc_a;
            if (inc_a == PTS_FORTY && cur_i.pts_b == PTS_FORTY) nxt_o.phase = PH_DEUCE;
          end
        end else if (ev_i == EV_B) begin
          if (cur_i.pts_b == PTS_FORTY) begin
            nxt_o.phase = PH_WIN_B;
          end else begin
            nxt_o.pts_b = inc_b;
            if (inc_b == PTS_FORTY && cur_i.pts_a == PTS_FORTY) nxt_o.phase = PH_DEUCE;
          end
        end
      end
      PH_DEUCE: begin
        if (ev_i == EV_A)      nxt_o.phase = PH_ADV_A;
        else if (ev_i == EV_B) nxt_o.phase = PH_ADV_B;
      end
      PH_ADV_A: begin
        if (ev_i == EV_A)      nxt_o.phase = PH_WIN_A;
        else if (ev_i == EV_B) nxt_o.phase = PH_DEUCE;
      end
      PH_ADV_B: begin
        if (ev_i == EV_B)      nxt_o.phase = PH_WIN_B;
        else if (ev_i == EV_A) nxt_o.phase = PH_DEUCE;
      end
      default: nxt_o = cur_i; // decided game holds
    endcase
  end
endmodule

// File: rtl/tennis_win_decode.sv
module tennis_win_decode
  import tennis_pkg::*;
(
  input  phase_e phase_i,
  output logic   a_wins_o,
  output logic   b_wins_o
);
  assign a_wins_o = (phase_i == PH_WIN_A);
  assign b_wins_o = (phase_i == PH_WIN_B);
endmodule

// File: rtl/tennis_score.sv
module tennis_score
  import tennis_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             a_i,
  input  logic             b_i,
  output logic [PH_W-1:0]  phase_o,
  output logic [PTS_W-1:0] pts_a_o,
  output logic [PTS_W-1:0] pts_b_o,
  output logic             a_wins_o,
  output logic             b_wins_o
);
  point_e ev;
  score_t score_q, score_d;

  tennis_point_decode u_dec (
    .a_i  (a_i),
    .b_i  (b_i),
    .ev_o (ev)
  );

  tennis_next u_next (
    .cur_i (score_q),
    .ev_i  (ev),
    .nxt_o (score_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      score_q <= SCORE_INIT;
    else if (clear_i) score_q <= SCORE_INIT;
    else              score_q <= score_d;
  end

  tennis_win_decode u_win (
    .phase_i  (score_q.phase),
    .a_wins_o (a_wins_o),
    .b_wins_o (b_wins_o)
  );

  assign phase_o = score_q.phase;
  assign pts_a_o = score_q.pts_a;
  assign pts_b_o = score_q.pts_b;
endmodule

// File: rtl/tennis_score_chk.sv
module tennis_score_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clear_i,
  input logic       a_i,
  input logic       b_i,
  input logic [2:0] phase_o,
  input logic [1:0] pts_a_o,
  input logic [1:0] pts_b_o,
  input logic       a_wins_o,
  input logic       b_wins_o
);
  a_r10_wins_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_wins_o && b_wins_o));

  a_r10_win_a_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_wins_o |-> phase_o == 3'd4);

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (phase_o == 3'd0 && pts_a_o == 2'd0 && pts_b_o == 2'd0 && !a_wins_o && !b_wins_o));

  a_r7_tie_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && (a_i == b_i)) |=> ($stable(phase_o) && $stable(pts_a_o) && $stable(pts_b_o)));

  a_r8_win_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && (a_wins_o || b_wins_o)) |=>
      ($stable(phase_o) && $stable(a_wins_o) && $stable(b_wins_o) && $stable(pts_a_o) && $stable(pts_b_o)));

  a_r6_adv_lost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && phase_o == 3'd2 && b_i && !a_i) |=> phase_o == 3'd1);

  a_r5_deuce_adv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && phase_o == 3'd1 && a_i && !b_i) |=> phase_o == 3'd2);

  a_r4_deuce_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd1) |-> (pts_a_o == 2'd3 && pts_b_o == 2'd3));
endmodule

bind tennis_score tennis_score_chk chk_i (.*);

// File: tb/tennis_score_tb_top.sv
`timescale 1ns/1ps
module tennis_score_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0;
  logic a_i = 1'b0;
  logic b_i = 1'b0;
  logic [2:0] phase_o;
  logic [1:0] pts_a_o, pts_b_o;
  logic a_wins_o, b_wins_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference: scores as tennis numbers, phase as named integer
  int sa, sb;
  string ph;

  always #2.5 clk_i = ~clk_i;

  tennis_score dut_i (.*);

  function automatic int nextpt(int s);
    if (s == 0) return 15;
    if (s == 15) return 30;
    return 40;
  endfunction

  function automatic int code_of(int s);
    case (s) 0: return 0; 15: return 1; 30: return 2; default: return 3; endcase
  endfunction

  function automatic int ph_code();
    case (ph)
      "play": return 0; "deuce": return 1; "advA": return 2;
      "advB": return 3; "wonA": return 4; default: return 5;
    endcase
  endfunction

  task automatic model_reset();
    sa = 0; sb = 0; ph = "play";
  endtask

  task automatic model_step(bit a, bit b, bit clr);
    if (clr) begin model_reset(); return; end
    if (a == b) return;
    if (ph == "play") begin
      if (a) begin
        if (sa == 40) ph = "wonA";
        else begin sa = nextpt(sa); if (sa == 40 && sb == 40) ph = "deuce"; end
      end else begin
        if (sb == 40) ph = "wonB";
        else begin sb = nextpt(sb); if (sa == 40 && sb == 40) ph = "deuce"; end
      end
    end else if (ph == "deuce") ph = a ? "advA" : "advB";
    else if (ph == "advA") ph = a ? "wonA" : "deuce";
    else if (ph == "advB") ph = b ? "wonB" : "deuce";
  endtask

  task automatic compare(string req);
    int ep, ea, eb;
    bit ewa, ewb;
    ep = ph_code(); ea = code_of(sa); eb = code_of(sb);
    ewa = (ep == 4); ewb = (ep == 5);
    checks++;
    if (phase_o !== ep[2:0] || pts_a_o !== ea[1:0] || pts_b_o !== eb[1:0] ||
        a_wins_o !== ewa || b_wins_o !== ewb) begin
      failures++;
      $display("FAIL %s: got phase=%0d a=%0d b=%0d wa=%0b wb=%0b exp phase=%0d a=%0d b=%0d wa=%0b wb=%0b",
               req, phase_o, pts_a_o, pts_b_o, a_wins_o, b_wins_o, ep, ea, eb, ewa, ewb);
    end
  endtask

  // drive, take one edge, then compare just after it
  task automatic step(bit a, bit b, bit clr, string req);
    a_i = a; b_i = b; clear_i = clr;
    @(posedge clk_i);
    model_step(a, b, clr);
    #1;
    compare(req);
  endtask

  task automatic pts(string seq, string req);
    for (int i = 0; i < seq.len(); i++)
      step(seq[i] == "A", seq[i] == "B", 1'b0, req);
  endtask

  task automatic restart();
    step(1'b0, 1'b0, 1'b1, "R9");
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    #1;
    compare("R1");                 // during reset
    #10 rst_ni = 1'b1;
    #1 compare("R1");

    pts("AAA", "R2");              // 40-love
    pts("A", "R3");                // A wins
    pts("ABAB", "R8");             // ignored in win
    step(1'b1, 1'b0, 1'b1, "R9");  // clear beats point

    pts("BBB", "R2");
    pts("B", "R3");
    pts("AA", "R8");
    restart();

    pts("AAABB", "R2");            // 40-30
    pts("B", "R4");                // deuce
    pts("A", "R5");
    pts("B", "R6");                // back to deuce
    pts("B", "R5");
    pts("A", "R6");
    pts("A", "R5");
    pts("A", "R6");                // A wins from advantage
    pts("B", "R8");
    restart();

    pts("BBBAA", "R2");            // 30-40
    pts("A", "R4");
    pts("B", "R5");
    pts("B", "R6");                // B wins from advantage
    restart();

    pts("AB", "R2");
    step(1'b1, 1'b1, 1'b0, "R7");
    step(1'b0, 1'b0, 1'b0, "R7");
    pts("AABB", "R4");
    step(1'b1, 1'b1, 1'b0, "R7");  // tie in deuce
    pts("A", "R5");
    step(1'b1, 1'b1, 1'b0, "R7");  // tie in advantage

    // async reset mid-game
    #1 rst_ni = 1'b0;
    #1 model_reset();
    compare("R1");
    @(negedge clk_i) rst_ni = 1'b1;
    #1 compare("R1");

    for (int n = 0; n < 3000; n++) begin
      bit ra, rb, rc;
      ra = $urandom_range(0, 1);
      rb = $urandom_range(0, 1);
      rc = ($urandom_range(0, 39) == 0);
      step(ra, rb, rc, "R10");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule